// File: doc/BRIEF.md
# Burst-4 Quad-Data-Rate SRAM Model

This block is a synthesizable model of a quad-data-rate static memory. Its write-data port and its read-data port are separate, so a read and a write can run at the same time. One address bus serves both ports. The model runs from a single clock `clk2x` at twice the K rate. A free-running two-bit slot counter marks the half-cycles: slots 0 and 2 stand for rising edges of K, and slots 1 and 3 stand for rising edges of K#. A read request is accepted at a slot-0 edge and a write request at a slot-2 edge, so the two requests share the address pins on alternating K edges.

Every access moves a fixed burst of four words, one word per half-cycle. The first read word appears five half-cycles (2.5 K cycles) after the read is registered. A valid flag and a complementary pair of echo clocks go with the read data, so the receiving logic can capture it. Writes are self-timed. The four beats are gathered with per-byte enables, and the burst is committed to the array internally with no handshake. A read that follows a write to the same burst address takes the merged new bytes from the write buffer, so it always returns the newest data.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0, `rvalid` is 0, `slot` is 0, `echo_p` is 0 and `echo_n` is 1.
- R2: `slot` advances by one (mod 4) on every `clk2x` edge. The first edge after reset carries slot 0. A slot-0 edge is a read-capture edge and a slot-2 edge is a write-capture edge.
- R3: When `rd_sel_n` is low at a slot-0 edge, the burst at `addr` is read. Word b (b = 0..3) is output after edge 5+b, counted from that capture edge. Word b is memory word {addr, b}.
- R4: `rvalid` is high exactly while a read word is driven. At all other times `rdata` holds 0.
- R5: When `wr_sel_n` is low at a slot-2 edge, the `wdata` values sampled at that edge and at the three following edges are stored to words {addr, 0} through {addr, 3}.
- R6: `bwe_n[i]` is sampled with each write beat. Low writes byte lane i (`wdata[i*BW +: BW]`, BW = DW/NB). High leaves that stored lane unchanged.
- R7: A port whose select is high at its capture edge does nothing. A read yields no `rvalid` and no data. A write leaves the array unchanged.
- R8: A read captured two edges after a write capture to the same burst address returns the written bytes, merged with the old bytes of the disabled lanes, even though that write commits in the same edge the read fetches.
- R9: A write captured two edges after a read capture (in the same K period) does not change the data returned by that read.
- R10: `echo_n` is always the complement of `echo_p`, and `echo_p` toggles on every edge. `echo_p` is high while read words 0 and 2 are driven and low while words 1 and 3 are driven.
- R11: Reads issued at consecutive slot-0 edges give an unbroken run of valid words, with no idle gap between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the K rate; each edge is one half-cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled at slot-0 edges |
| wr_sel_n | input | 1 | Active-low write request, sampled at slot-2 edges |
| addr | input | AW | Shared burst address: read address at slot 0, write address at slot 2 |
| bwe_n | input | NB | Active-low byte-lane write enables, one per write beat |
| wdata | input | DW | Write data, one beat per edge |
| rdata | output | DW | Read data, one word per edge, 0 when idle |
| rvalid | output | 1 | High while `rdata` carries a read word |
| echo_p | output | 1 | Echo clock aligned to read words |
| echo_n | output | 1 | Complement of `echo_p` |
| slot | output | 2 | Current half-cycle slot number |

## Verification
The hard overlap is a read fetch and a write commit landing on the same edge for the same burst address. In that edge the array still holds the old words while the last write beat is still on the pins. Directed periods place a partial-enable write at slot 2 followed by a read of that address at the next slot 0, and also the reverse order inside one period. A long random run over only eight addresses keeps producing such collisions. Each returned word is judged against a reference memory in the bench. That memory applies every write burst when its last beat arrives and snapshots the read burst at the edge after the read capture.

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int AW = 6,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] bwe_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          echo_p,
  output logic          echo_n,
  output logic [1:0]    slot
);
  localparam int BW    = DW / NB;
  localparam int WORDS = 4 * (1 << AW);

  logic [1:0]    ph;
  logic          rd_go, wr_go, fv, ov;
  logic [AW-1:0] rd_a, wr_a;
  logic [DW-1:0] wb [3];
  logic [NB-1:0] wm [3];
  logic [DW-1:0] bd [4];
  logic [NB-1:0] bm [4];
  logic [DW-1:0] fetch [4];
  logic [DW-1:0] fbuf [4];
  logic [DW-1:0] obuf [3];
  logic [BW-1:0] mem [NB][WORDS];
  logic          fwd;

  assign slot = ph;
  assign fwd  = wr_go && (wr_a == rd_a);

  always_comb begin
    for (int b = 0; b < 3; b++) begin
      bd[b] = wb[b];
      bm[b] = wm[b];
    end
    bd[3] = wdata;
    bm[3] = ~bwe_n;
  end

  always_comb begin
    for (int b = 0; b < 4; b++)
      for (int l = 0; l < NB; l++)
        fetch[b][l*BW +: BW] = (fwd && bm[b][l]) ? bd[b][l*BW +: BW]
                                                 : mem[l][{rd_a, 2'(b)}];
  end

  always_ff @(posedge clk2x) begin
    if (ph == 2'd1 && wr_go)
      for (int b = 0; b < 4; b++)
        for (int l = 0; l < NB; l++)
          if (bm[b][l]) mem[l][{wr_a, 2'(b)}] <= bd[b][l*BW +: BW];
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      rd_go  <= 1'b0;
      wr_go  <= 1'b0;
      rd_a   <= '0;
      wr_a   <= '0;
      fv     <= 1'b0;
      ov     <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
      echo_p <= 1'b0;
      echo_n <= 1'b1;
      for (int i = 0; i < 3; i++) begin
        wb[i]   <= '0;
        wm[i]   <= '0;
        obuf[i] <= '0;
      end
      for (int i = 0; i < 4; i++) fbuf[i] <= '0;
    end else begin
      ph     <= ph + 2'd1;
      echo_p <= ph[0];
      echo_n <= ~ph[0];
      case (ph)
        2'd0: begin
          rd_go  <= ~rd_sel_n;
          rd_a   <= addr;
          wb[2]  <= wdata;
          wm[2]  <= ~bwe_n;
          rvalid <= ov;
          rdata  <= ov ? obuf[2] : '0;
        end
        2'd1: begin
          fv     <= rd_go;
          ov     <= fv;
          for (int i = 0; i < 4; i++) fbuf[i] <= fetch[i];
          for (int i = 0; i < 3; i++) obuf[i] <= fbuf[i+1];
          rvalid <= fv;
          rdata  <= fv ? fbuf[0] : '0;
        end
        2'd2: begin
          wr_go  <= ~wr_sel_n;
          wr_a   <= addr;
          wb[0]  <= wdata;
          wm[0]  <= ~bwe_n;
          rvalid <= ov;
          rdata  <= ov ? obuf[0] : '0;
        end
        default: begin
          wb[1]  <= wdata;
          wm[1]  <= ~bwe_n;
          rvalid <= ov;
          rdata  <= ov ? obuf[1] : '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk2x,
  input logic          rst_n,
  input logic          rd_sel_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          echo_p,
  input logic          echo_n,
  input logic [1:0]    slot
);
  // R2
  slot_step_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    rst_n |=> slot == 2'($past(slot) + 2'd1));

  // R10
  echo_pair_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    echo_n == ~echo_p);

  // R10
  echo_beat_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (rvalid && slot == 2'd2) |-> echo_p);

  // R3
  rd_latency_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (rvalid && slot == 2'd2) |-> !$past(rd_sel_n, 6));

  // R7
  rd_issue_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (slot == 2'd0 && !rd_sel_n) |-> ##6 rvalid);

  // R4
  idle_zero_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rdata(rdata),
  .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n), .slot(slot));

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, DW = 18, NB = 2;
  localparam int BW = DW / NB;
  localparam int WORDS = 4 * (1 << AW);
  localparam int MAXE = 2048;

  logic clk2x = 1'b0, rst_n = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bwe_n = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, echo_p, echo_n;
  logic [1:0] slot;

  qdr_burst_sram #(.AW(AW), .DW(DW), .NB(NB)) u_dut (
    .clk2x(clk2x), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .bwe_n(bwe_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .echo_p(echo_p), .echo_n(echo_n), .slot(slot));

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  int checks = 0, fails = 0, n = 0;
  logic [DW-1:0] ref_mem [WORDS];
  logic          exp_v [MAXE];
  logic [DW-1:0] exp_d [MAXE];
  string         exp_t [MAXE];
  logic          w_act = 1'b0, r_go = 1'b0;
  logic [AW-1:0] w_a = '0, r_a = '0;
  logic [DW-1:0] w_d [4];
  logic [NB-1:0] w_bn [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s edge=%0d actual=%h expected=%h", tag, what, n, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] pick_bn(input int mode);
    if (mode == 1) return NB'($urandom);
    if (mode == 2) return NB'(1);
    return '0;
  endfunction

  task automatic do_edge(input logic rsn, input logic wsn, input logic [AW-1:0] a,
                         input logic [NB-1:0] bn, input string tag);
    int s;
    s = n % 4;
    rd_sel_n = rsn; wr_sel_n = wsn; addr = a; bwe_n = bn; wdata = DW'($urandom);
    @(posedge clk2x);
    case (s)
      2: begin
        w_act = !wsn; w_a = a; w_d[0] = wdata; w_bn[0] = bn;
      end
      3: begin w_d[1] = wdata; w_bn[1] = bn; end
      0: begin
        w_d[2] = wdata; w_bn[2] = bn;
        r_go = !rsn; r_a = a;
      end
      default: begin
        w_d[3] = wdata; w_bn[3] = bn;
        if (w_act)
          for (int b = 0; b < 4; b++)
            for (int l = 0; l < NB; l++)
              if (!w_bn[b][l]) ref_mem[{w_a, 2'(b)}][l*BW +: BW] = w_d[b][l*BW +: BW];
        if (r_go && n + 7 < MAXE)
          for (int b = 0; b < 4; b++) begin
            exp_v[n+4+b] = 1'b1;
            exp_d[n+4+b] = ref_mem[{r_a, 2'(b)}];
            exp_t[n+4+b] = tag;
          end
      end
    endcase
    @(negedge clk2x);
    chk(rvalid === exp_v[n], "R4", "rvalid", DW'(rvalid), DW'(exp_v[n]));
    if (exp_v[n])
      chk(rdata === exp_d[n], exp_t[n], "rdata", rdata, exp_d[n]);
    else
      chk(rdata === '0, "R4", "idle rdata", rdata, '0);
    chk(slot === 2'(n + 1), "R2", "slot", DW'(slot), DW'(2'(n + 1)));
    chk(echo_p === s[0] && echo_n === !s[0], "R10", "echo_p", DW'(echo_p), DW'(s[0]));
    n++;
  endtask

  task automatic period(input bit rd, input logic [AW-1:0] ra, input bit wr,
                        input logic [AW-1:0] wa, input int bmode, input string tag);
    do_edge(!rd, 1'b1, ra, pick_bn(bmode), tag);
    do_edge(1'b1, 1'b1, AW'($urandom), pick_bn(bmode), tag);
    do_edge(1'b1, !wr, wa, pick_bn(bmode), tag);
    do_edge(1'b1, 1'b1, AW'($urandom), pick_bn(bmode), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired at edge %0d", n);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int vr;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < MAXE; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "R3"; end
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk2x);
    chk(rdata === '0 && rvalid === 1'b0, "R1", "reset data/valid", rdata, '0);
    chk(slot === 2'd0, "R1", "reset slot", DW'(slot), '0);
    chk(echo_p === 1'b0 && echo_n === 1'b1, "R1", "reset echo", DW'({echo_p, echo_n}), DW'(2'b01));
    rst_n = 1'b1;

    // R5: fill every burst address with all lanes enabled
    for (int a = 0; a < (1 << AW); a++) period(1'b0, '0, 1'b1, AW'(a), 0, "R5");
    // R3/R5: read back a few
    period(1'b1, 6'd3, 1'b0, '0, 0, "R5");
    period(1'b1, 6'd40, 1'b0, '0, 0, "R3");
    period(1'b0, '0, 1'b0, '0, 0, "R3");
    // R6: lane 0 disabled on every beat, then read
    period(1'b0, '0, 1'b1, 6'd9, 2, "R6");
    period(1'b0, '0, 1'b0, '0, 0, "R6");
    period(1'b1, 6'd9, 1'b0, '0, 0, "R6");
    // R7: deselected write, deselected read, then read back
    period(1'b0, 6'd9, 1'b0, 6'd9, 0, "R7");
    period(1'b0, '0, 1'b0, '0, 0, "R7");
    period(1'b1, 6'd9, 1'b0, '0, 0, "R7");
    // R8: write then read same address in next slot 0 (forwarding, partial lanes)
    period(1'b0, '0, 1'b1, 6'd17, 1, "R8");
    period(1'b1, 6'd17, 1'b0, '0, 1, "R8");
    period(1'b0, '0, 1'b1, 6'd18, 0, "R8");
    period(1'b1, 6'd18, 1'b0, '0, 0, "R8");
    // R9: read then write same address in the same period
    period(1'b1, 6'd22, 1'b1, 6'd22, 0, "R9");
    period(1'b1, 6'd22, 1'b0, '0, 0, "R9");
    // R11: back-to-back reads
    for (int k = 0; k < 6; k++) period(1'b1, AW'(k * 5), 1'b0, '0, 0, "R11");
    // R3: random traffic over eight addresses
    for (int k = 0; k < 300; k++) begin
      vr = int'($urandom % 4);
      period(vr[0], AW'($urandom % 8), vr[1], AW'($urandom % 8), 1, "R3");
    end
    repeat (3) period(1'b0, '0, 1'b0, '0, 0, "R4");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule